// File: doc/BRIEF.md
# Indirect-Access Interrupt Routing Register File

This block holds the per-pin routing configuration of an interrupt router. Software reaches it through two locations on a small memory-mapped bus: a select register that names an internal register, and a 32-bit data window that reads or writes whatever the select register currently names. Behind the window sit a version word, a 4-bit identifier and one 64-bit routing entry per interrupt pin. Each entry is reached as two 32-bit halves.

The delivery logic next to this block reads the decoded fields of every entry in parallel: vector, delivery mode, destination mode, delivery status, polarity, remote-IRR, trigger mode, mask and destination. It drives per-pin commands that set or clear remote-IRR. The block keeps the status bits it owns intact across software writes. It holds remote-IRR clear on edge-triggered entries. It emits a one-cycle notice whenever a software write flips a pin's mask bit.

Top module: `irq_route_regs`

## Requirements
- R1: The bus decodes byte offset 0x00 as the select register, read back as {24'b0, select}, and byte offset 0x10 as the data window. Any other offset reads 0, and a write to it changes nothing.
- R2: A write to the select register keeps only bits 7:0 of the write data.
- R3: Select index 0x01 reads the version word: (pin count − 1) in bits 23:16 and the version code in bits 7:0, with 0x00170020 for the defaults. A window write at this index has no effect.
- R4: Select indices 0x00 and 0x02 both read the 4-bit identifier in bits 27:24, with all other bits 0. A window write at index 0x00 loads the identifier from bits 27:24 of the write data. A window write at index 0x02 has no effect.
- R5: Select index 0x10+2n addresses bits 31:0 of entry n, and 0x11+2n addresses bits 63:32. A window write replaces only the addressed half. The entry layout is: vector [7:0], delivery mode [10:8], destination mode [11], delivery status [12], polarity [13], remote-IRR [14], trigger mode [15] (1 = level), mask [16], destination [63:56].
- R6: An index in 0x03..0x0F, or one whose entry number is at or beyond the pin count, reads 0xFFFFFFFF. A window write to such an index changes no entry.
- R7: A window write leaves remote-IRR (bit 14) and delivery status (bit 12) at their previous values. Delivery status has no other writer, so it stays 0.
- R8: While an entry's trigger-mode bit is 0 (edge), its remote-IRR is 0. A write that selects edge mode clears the bit, and a set command on an edge entry is ignored.
- R9: For a level entry, a set command makes remote-IRR 1 and a clear command makes it 0, taking effect one clock later. When both commands arrive in the same cycle, set wins.
- R10: After reset every entry has its mask bit set and all other bits 0, and the select register and the identifier are 0.
- R11: A window write that changes an entry's mask bit raises mask_chg_valid for exactly the cycle after the write, with the entry number and the new mask value. A write that leaves the mask unchanged raises no notice.
- R12: The field outputs show each entry's current contents, packed per pin at bit offset pin × field width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| hw_set_rirr | input | NUM_PINS | Per-pin remote-IRR set command |
| hw_clr_rirr | input | NUM_PINS | Per-pin remote-IRR clear command |
| ent_vector | output | NUM_PINS*8 | Vector of every entry |
| ent_dlv_mode | output | NUM_PINS*3 | Delivery mode of every entry |
| ent_dst_mode | output | NUM_PINS | Destination mode bit per entry |
| ent_dlv_stat | output | NUM_PINS | Delivery status bit per entry |
| ent_polarity | output | NUM_PINS | Polarity bit per entry |
| ent_rirr | output | NUM_PINS | Remote-IRR bit per entry |
| ent_level | output | NUM_PINS | Trigger mode per entry (1 = level) |
| ent_mask | output | NUM_PINS | Mask bit per entry |
| ent_dest | output | NUM_PINS*8 | Destination of every entry |
| mask_chg_valid | output | 1 | One-cycle mask change notice |
| mask_chg_pin | output | $clog2(NUM_PINS) | Entry whose mask changed |
| mask_chg_mask | output | 1 | New mask value |

## Verification
The hardest state to reach is an entry whose remote-IRR is already 1 while software rewrites that entry. Software can never set the bit itself. The stimulus therefore first makes the entry level-triggered and unmasked through the window. It then pulses the hardware set command, and only after that issues window writes. It checks that a level rewrite leaves the bit set and that switching the entry to edge mode clears it. Simultaneous set and clear commands, writes to out-of-range indices, and rewrites that leave the mask unchanged are driven the same way, and each is observed at the field outputs or through the window.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    // One routing entry, most significant field first.
    typedef struct packed {
        logic [7:0]  dest;
        logic [38:0] rsvd;
        logic        mask;
        logic        level;
        logic        rirr;
        logic        polarity;
        logic        dstat;
        logic        dst_mode;
        logic [2:0]  dlv_mode;
        logic [7:0]  vector;
    } route_ent_t;

    localparam int          SEL_W    = 8;
    localparam logic [7:0]  IDX_ID   = 8'h00;
    localparam logic [7:0]  IDX_VER  = 8'h01;
    localparam logic [7:0]  IDX_ARB  = 8'h02;
    localparam logic [7:0]  IDX_ENT0 = 8'h10;
    localparam logic [7:0]  OFF_SEL  = 8'h00;
    localparam logic [7:0]  OFF_WIN  = 8'h10;

    localparam route_ent_t  ENT_RESET = '{mask: 1'b1, default: '0};

endpackage

// File: rtl/route_sel_decode.sv
module route_sel_decode
    import irq_route_pkg::*;
#(
    parameter int NUM_PINS = 24,
    localparam int PIN_W = $clog2(NUM_PINS)
) (
    input  logic [SEL_W-1:0] sel,
    output logic             is_ver,
    output logic             is_id,
    output logic             is_arb,
    output logic             ent_ok,
    output logic             hi_half,
    output logic [PIN_W-1:0] ent_idx
);

    logic [6:0] idx7;

    always_comb begin
        idx7    = 7'((sel - IDX_ENT0) >> 1);
        is_ver  = (sel == IDX_VER);
        is_id   = (sel == IDX_ID);
        is_arb  = (sel == IDX_ARB);
        ent_ok  = (sel >= IDX_ENT0) && (32'(idx7) < NUM_PINS);
        hi_half = sel[0];
        ent_idx = PIN_W'(idx7);
    end

endmodule

// File: rtl/route_entry.sv
module route_entry
    import irq_route_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    input  logic        set_rirr,
    input  logic        clr_rirr,
    output route_ent_t  ent_q,
    output logic        mask_flip
);

    route_ent_t ent_d;

    always_comb begin
        ent_d = ent_q;
        if (wr_lo) ent_d[31:0]  = wdata;
        if (wr_hi) ent_d[63:32] = wdata;
        // hardware-owned bits survive the write
        ent_d.rirr  = ent_q.rirr;
        ent_d.dstat = ent_q.dstat;
        if (set_rirr)      ent_d.rirr = 1'b1;
        else if (clr_rirr) ent_d.rirr = 1'b0;
        if (!ent_d.level)  ent_d.rirr = 1'b0;
        mask_flip = wr_lo && (ent_d.mask != ent_q.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ent_q <= ENT_RESET;
        else        ent_q <= ent_d;
    end

    AST_EDGE_NO_RIRR: assert property (@(posedge clk) disable iff (!rst_n)
        !ent_q.level |-> !ent_q.rirr); // R8
    AST_SET_RIRR: assert property (@(posedge clk) disable iff (!rst_n)
        (set_rirr && ent_q.level && !wr_lo) |=> ent_q.rirr); // R9
    AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !set_rirr && !clr_rirr) |=> (ent_q[31:0] == $past(ent_q[31:0]))); // R5
    AST_DSTAT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (ent_q.dstat == $past(ent_q.dstat))); // R7

endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int          NUM_PINS = 24,
    parameter logic [7:0]  VERSION  = 8'h20,
    localparam int PIN_W = $clog2(NUM_PINS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [7:0]            bus_addr,
    input  logic                  bus_we,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NUM_PINS-1:0]   hw_set_rirr,
    input  logic [NUM_PINS-1:0]   hw_clr_rirr,
    output logic [NUM_PINS*8-1:0] ent_vector,
    output logic [NUM_PINS*3-1:0] ent_dlv_mode,
    output logic [NUM_PINS-1:0]   ent_dst_mode,
    output logic [NUM_PINS-1:0]   ent_dlv_stat,
    output logic [NUM_PINS-1:0]   ent_polarity,
    output logic [NUM_PINS-1:0]   ent_rirr,
    output logic [NUM_PINS-1:0]   ent_level,
    output logic [NUM_PINS-1:0]   ent_mask,
    output logic [NUM_PINS*8-1:0] ent_dest,
    output logic                  mask_chg_valid,
    output logic [PIN_W-1:0]      mask_chg_pin,
    output logic                  mask_chg_mask
);

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [3:0]       id;
        logic             mc_v;
        logic [PIN_W-1:0] mc_pin;
        logic             mc_val;
    } top_state_t;

    localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION};

    top_state_t s_d, s_q;

    logic             is_ver, is_id, is_arb, ent_ok, hi_half;
    logic [PIN_W-1:0] ent_idx;
    logic             sel_hit, win_hit, wr_win;
    logic [NUM_PINS-1:0] flips;
    logic [NUM_PINS-1:0] wr_lo, wr_hi;
    route_ent_t       ent_q [NUM_PINS];
    route_ent_t       ent_pick;
    logic [31:0]      win_word;

    route_sel_decode #(.NUM_PINS(NUM_PINS)) u_dec (
        .sel     (s_q.sel),
        .is_ver  (is_ver),
        .is_id   (is_id),
        .is_arb  (is_arb),
        .ent_ok  (ent_ok),
        .hi_half (hi_half),
        .ent_idx (ent_idx)
    );

    assign sel_hit = (bus_addr == OFF_SEL);
    assign win_hit = (bus_addr == OFF_WIN);
    assign wr_win  = bus_we && win_hit;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
        assign wr_lo[g] = wr_win && ent_ok && !hi_half && (ent_idx == PIN_W'(g));
        assign wr_hi[g] = wr_win && ent_ok &&  hi_half && (ent_idx == PIN_W'(g));

        route_entry u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_lo     (wr_lo[g]),
            .wr_hi     (wr_hi[g]),
            .wdata     (bus_wdata),
            .set_rirr  (hw_set_rirr[g]),
            .clr_rirr  (hw_clr_rirr[g]),
            .ent_q     (ent_q[g]),
            .mask_flip (flips[g])
        );

        assign ent_vector[g*8 +: 8]   = ent_q[g].vector;
        assign ent_dlv_mode[g*3 +: 3] = ent_q[g].dlv_mode;
        assign ent_dst_mode[g]        = ent_q[g].dst_mode;
        assign ent_dlv_stat[g]        = ent_q[g].dstat;
        assign ent_polarity[g]        = ent_q[g].polarity;
        assign ent_rirr[g]            = ent_q[g].rirr;
        assign ent_level[g]           = ent_q[g].level;
        assign ent_mask[g]            = ent_q[g].mask;
        assign ent_dest[g*8 +: 8]     = ent_q[g].dest;
    end

    // read path
    always_comb begin
        ent_pick = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (ent_idx == PIN_W'(i)) ent_pick = ent_q[i];
        end
        if (is_ver)               win_word = VER_WORD;
        else if (is_id || is_arb) win_word = {4'b0, s_q.id, 24'b0};
        else if (ent_ok)          win_word = hi_half ? ent_pick[63:32] : ent_pick[31:0];
        else                      win_word = '1;

        if (sel_hit)      bus_rdata = {24'b0, s_q.sel};
        else if (win_hit) bus_rdata = win_word;
        else              bus_rdata = '0;
    end

    // next state
    always_comb begin
        s_d      = s_q;
        s_d.mc_v = 1'b0;
        if (bus_we && sel_hit) s_d.sel = bus_wdata[7:0];
        if (wr_win && is_id)   s_d.id  = bus_wdata[27:24];
        if (|flips) begin
            s_d.mc_v   = 1'b1;
            s_d.mc_pin = ent_idx;
            s_d.mc_val = bus_wdata[16];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mask_chg_valid = s_q.mc_v;
    assign mask_chg_pin   = s_q.mc_pin;
    assign mask_chg_mask  = s_q.mc_val;

    AST_ONE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flips)); // R11
    AST_PULSE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        mask_chg_valid |-> (ent_mask[mask_chg_pin] == mask_chg_mask)); // R11
    AST_SEL_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel_hit) |=> (s_q.sel == $past(bus_wdata[7:0]))); // R2
    AST_BAD_IDX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_win && !ent_ok) |-> (flips == '0)); // R6

endmodule

// File: tb/tb_irq_route_regs.sv
`timescale 1ns/1ps
module tb_irq_route_regs;

    localparam int NP = 24;
    localparam int PW = $clog2(NP);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic            bus_we = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NP-1:0]   hw_set_rirr = '0;
    logic [NP-1:0]   hw_clr_rirr = '0;
    logic [NP*8-1:0] ent_vector, ent_dest;
    logic [NP*3-1:0] ent_dlv_mode;
    logic [NP-1:0]   ent_dst_mode, ent_dlv_stat, ent_polarity, ent_rirr, ent_level, ent_mask;
    logic            mask_chg_valid, mask_chg_mask;
    logic [PW-1:0]   mask_chg_pin;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_route_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hw_set_rirr(hw_set_rirr), .hw_clr_rirr(hw_clr_rirr),
        .ent_vector(ent_vector), .ent_dlv_mode(ent_dlv_mode), .ent_dst_mode(ent_dst_mode),
        .ent_dlv_stat(ent_dlv_stat), .ent_polarity(ent_polarity), .ent_rirr(ent_rirr),
        .ent_level(ent_level), .ent_mask(ent_mask), .ent_dest(ent_dest),
        .mask_chg_valid(mask_chg_valid), .mask_chg_pin(mask_chg_pin),
        .mask_chg_mask(mask_chg_mask)
    );

    // row: {write, offset, data, requirement number}
    localparam int ROWS = 33;
    localparam logic [44:0] VEC [0:ROWS-1] = '{
        {1'b0, 8'h00, 32'h00000000, 4'd10}, // R10 select after reset
        {1'b1, 8'h00, 32'hABCD1201, 4'd2 }, // R2
        {1'b0, 8'h00, 32'h00000001, 4'd2 },
        {1'b0, 8'h10, 32'h00170020, 4'd3 }, // R3 version
        {1'b1, 8'h10, 32'hFFFFFFFF, 4'd3 },
        {1'b0, 8'h10, 32'h00170020, 4'd3 },
        {1'b1, 8'h00, 32'h00000000, 4'd4 }, // R4 identifier
        {1'b1, 8'h10, 32'hFA000000, 4'd4 },
        {1'b0, 8'h10, 32'h0A000000, 4'd4 },
        {1'b1, 8'h00, 32'h00000002, 4'd4 },
        {1'b0, 8'h10, 32'h0A000000, 4'd4 },
        {1'b1, 8'h10, 32'h05000000, 4'd4 },
        {1'b0, 8'h10, 32'h0A000000, 4'd4 },
        {1'b1, 8'h00, 32'h00000010, 4'd10}, // R10 entry reset value
        {1'b0, 8'h10, 32'h00010000, 4'd10},
        {1'b1, 8'h10, 32'h0000FF31, 4'd7 }, // R7 status bits kept
        {1'b0, 8'h10, 32'h0000AF31, 4'd7 },
        {1'b1, 8'h00, 32'h00000011, 4'd5 }, // R5 halves
        {1'b1, 8'h10, 32'h5A000000, 4'd5 },
        {1'b0, 8'h10, 32'h5A000000, 4'd5 },
        {1'b1, 8'h00, 32'h00000010, 4'd5 },
        {1'b0, 8'h10, 32'h0000AF31, 4'd5 },
        {1'b1, 8'h00, 32'h00000040, 4'd6 }, // R6 out of range
        {1'b0, 8'h10, 32'hFFFFFFFF, 4'd6 },
        {1'b1, 8'h10, 32'h12345678, 4'd6 },
        {1'b1, 8'h00, 32'h00000003, 4'd6 },
        {1'b0, 8'h10, 32'hFFFFFFFF, 4'd6 },
        {1'b1, 8'h00, 32'h0000003E, 4'd6 },
        {1'b0, 8'h10, 32'h00010000, 4'd6 },
        {1'b1, 8'h04, 32'h00000055, 4'd1 }, // R1 other offsets
        {1'b0, 8'h04, 32'h00000000, 4'd1 },
        {1'b0, 8'h00, 32'h0000003E, 4'd1 },
        {1'b0, 8'h10, 32'h00010000, 4'd1 }
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        #1;
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic hw_cmd(input logic [NP-1:0] s, input logic [NP-1:0] c);
        @(negedge clk);
        hw_set_rirr = s; hw_clr_rirr = c;
        @(negedge clk);
        hw_set_rirr = '0; hw_clr_rirr = '0;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R10 mask after reset", 32'(ent_mask), 32'(24'hFFFFFF));
        check("R10 rirr after reset", 32'(ent_rirr), 32'h0);
        check("R10 no notice after reset", 32'(mask_chg_valid), 32'h0);

        for (int i = 0; i < ROWS; i++) begin
            if (VEC[i][44]) bus_wr(VEC[i][43:36], VEC[i][35:4]);
            else bus_rd(VEC[i][43:36], VEC[i][35:4], $sformatf("R%0d row %0d", VEC[i][3:0], i));
        end

        // R12 field outputs of entry 0
        check("R12 vector", 32'(ent_vector[7:0]), 32'h31);
        check("R12 delivery mode", 32'(ent_dlv_mode[2:0]), 32'h7);
        check("R12 dest mode", 32'(ent_dst_mode[0]), 32'h1);
        check("R12 polarity", 32'(ent_polarity[0]), 32'h1);
        check("R12 level", 32'(ent_level[0]), 32'h1);
        check("R12 mask", 32'(ent_mask[0]), 32'h0);
        check("R12 dest", 32'(ent_dest[7:0]), 32'h5A);
        check("R12 delivery status", 32'(ent_dlv_stat), 32'h0);

        // R11 mask change notice on entry 2
        bus_wr(8'h00, 32'h14);
        bus_wr(8'h10, 32'h00008040);
        check("R11 notice valid", 32'(mask_chg_valid), 32'h1);
        check("R11 notice pin", 32'(mask_chg_pin), 32'h2);
        check("R11 notice value", 32'(mask_chg_mask), 32'h0);
        @(negedge clk); #1;
        check("R11 notice one cycle", 32'(mask_chg_valid), 32'h0);
        bus_wr(8'h10, 32'h00008041);
        check("R11 no notice if unchanged", 32'(mask_chg_valid), 32'h0);

        // R9 hardware remote-IRR commands
        hw_cmd(24'h000004, 24'h0);
        check("R9 set", 32'(ent_rirr[2]), 32'h1);
        bus_rd(8'h10, 32'h0000C041, "R9 set visible in window");
        bus_wr(8'h10, 32'h00008042);
        check("R7 rirr kept over level write", 32'(ent_rirr[2]), 32'h1);
        hw_cmd(24'h000004, 24'h000004);
        check("R9 set wins", 32'(ent_rirr[2]), 32'h1);
        hw_cmd(24'h0, 24'h000004);
        check("R9 clear", 32'(ent_rirr[2]), 32'h0);
        hw_cmd(24'h000004, 24'h0);
        check("R9 set again", 32'(ent_rirr[2]), 32'h1);

        // R8 edge mode forces remote-IRR clear
        bus_wr(8'h10, 32'h00000043);
        check("R8 edge write clears", 32'(ent_rirr[2]), 32'h0);
        hw_cmd(24'h000004, 24'h0);
        check("R8 set ignored on edge", 32'(ent_rirr[2]), 32'h0);
        bus_rd(8'h10, 32'h00000043, "R8 window after edge");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule